// File: doc/BRIEF.md
# I/O Line Cache with State-Ranked Replacement

This block is a small set-associative cache that keeps only data moved by a DMA engine. It sits beside the processor's last-level cache, not inside it. It serves three kinds of request. A DMA read fills the line from memory on a miss. A DMA write allocates the line on a miss. A lookup forwarded from the CPU side returns the line on a hit and leaves the cache untouched on a miss. Requests move whole 64-byte lines (512 bits by default), addressed by line number. The low address bits select the set and the rest form the tag.

Each line is Invalid, Clean or Dirty. When a miss needs a way, the victim is ranked by state rather than by age alone. An Invalid way is taken first. If there is none, the oldest Clean way is taken. The oldest Dirty way is taken only when the whole set is Dirty, and it is written back to memory before the new line is placed there. A mode input, sampled when a request is accepted, selects write-back or write-through. Memory is reached through a request/ready port, and read data returns on a separate valid strobe.

Top module: `io_line_cache`

## Requirements
- R1: After reset every line is Invalid, so every lookup misses; `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R2: On a miss that allocates, an Invalid way of the set is used if one exists (the lowest-numbered Invalid way), so no valid line is displaced.
- R3: With no Invalid way, the least recently used Clean way is replaced, even if a Dirty way is older; replacing a Clean way causes no memory write.
- R4: A Dirty way is replaced only when all ways of the set are Dirty, and then the least recently used one is chosen and written to memory at its own line address with its own data.
- R5: Recency is updated on every hit (DMA read, DMA write or CPU lookup) and on every fill, and each set keeps its ways in a strict age order.
- R6: A DMA write (`req_op`=1) that misses installs the line without reading memory (write-allocate); in write-back mode (`wt_mode`=0) it produces no memory write and leaves the line Dirty; `resp_hit` reports whether it hit.
- R7: In write-through mode (`wt_mode`=1) every DMA write also writes the line to memory and leaves it Clean; no line ever becomes Dirty in this mode.
- R8: A DMA read (`req_op`=0) that misses fetches the line from memory, installs it Clean and returns that data with `resp_hit`=0; a DMA read that hits returns the cached data with `resp_hit`=1.
- R9: When a Dirty victim is evicted, its memory write completes before the refill read is requested, and the refill lands in that way only afterwards.
- R10: A CPU lookup (`req_op`=2) that hits returns the line with `resp_hit`=1; one that misses returns `resp_hit`=0 with zero data, causes no memory traffic and allocates nothing.
- R11: A memory request keeps `mem_req_valid`, address, direction and data stable until `mem_req_ready` accepts it, and at most one memory request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 selects write-through, 0 write-back; sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request this cycle |
| req_op | input | 2 | 0 DMA read, 1 DMA write, 2 CPU lookup |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | LINE_BITS | Line data for a DMA write |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | LINE_BITS | Line data for reads; zero for writes and lookup misses |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Line address for memory |
| mem_req_wdata | output | LINE_BITS | Line data for a memory write |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | LINE_BITS | Read data from memory |

## Verification
The bench fills one set with Dirty lines and then forces a read miss. A design that evicted by plain age, or that fetched before writing back, would show the wrong write-back address or the wrong event order. It then leaves a single Clean way among older Dirty ones. A design that let any Dirty line go first would issue a memory write where none is due. Write-through writes that hit a Dirty line and then a later write-back allocation check that no Dirty state leaked in that mode. CPU lookup hits that reorder recency, and lookup misses that must not allocate, are checked against an independent timestamp model through a long mixed sweep with an irregular memory ready signal.

// File: rtl/io_cache_pkg.sv
package io_cache_pkg;

    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_CLEAN = 2'd1,
        LN_DIRTY = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_DMA_RD = 2'd0,
        OP_DMA_WR = 2'd1,
        OP_CPU_RD = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LOOK,
        F_EVICT,
        F_FETCH,
        F_WAIT,
        F_PUT,
        F_THRU
    } fsm_e;

endpackage

// File: rtl/io_cache_age.sv
module io_cache_age #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SET_W-1:0]      rd_set,
    input  logic                  touch_en,
    input  logic [SET_W-1:0]      touch_set,
    input  logic [IDX_W-1:0]      touch_way,
    output logic [WAYS*IDX_W-1:0] age_flat
);
    logic [IDX_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= IDX_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (IDX_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + IDX_W'(1);
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++)
            age_flat[w*IDX_W +: IDX_W] = age_q[rd_set][w];
    end

    // every age value appears exactly once in the observed set
    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++)
            seen[age_q[rd_set][w]] = 1'b1;
    end

    assert_age_order_R5: assert property (@(posedge clk) disable iff (rst) &seen);

endmodule

// File: rtl/io_cache_victim.sv
module io_cache_victim
    import io_cache_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WAYS*2-1:0]     st_flat,
    input  logic [WAYS*IDX_W-1:0] age_flat,
    output logic [IDX_W-1:0]      vic
);
    logic             inv_any, cl_any, dt_any;
    logic [IDX_W-1:0] inv_w, cl_w, dt_w, cl_age, dt_age;
    logic [WAYS-1:0]  is_inv, is_cl, is_dt;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            is_inv[w] = (st_flat[w*2 +: 2] == LN_INV);
            is_cl[w]  = (st_flat[w*2 +: 2] == LN_CLEAN);
            is_dt[w]  = (st_flat[w*2 +: 2] == LN_DIRTY);
        end
    end

    always_comb begin
        inv_any = 1'b0; inv_w = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (is_inv[w]) begin
                inv_any = 1'b1;
                inv_w   = IDX_W'(w);
            end
        end
        cl_any = 1'b0; cl_w = '0; cl_age = '0;
        dt_any = 1'b0; dt_w = '0; dt_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (is_cl[w] && (!cl_any || age_flat[w*IDX_W +: IDX_W] > cl_age)) begin
                cl_any = 1'b1;
                cl_w   = IDX_W'(w);
                cl_age = age_flat[w*IDX_W +: IDX_W];
            end
            if (is_dt[w] && (!dt_any || age_flat[w*IDX_W +: IDX_W] > dt_age)) begin
                dt_any = 1'b1;
                dt_w   = IDX_W'(w);
                dt_age = age_flat[w*IDX_W +: IDX_W];
            end
        end
        vic = inv_any ? inv_w : (cl_any ? cl_w : dt_w);
    end

    assert_pick_invalid_R2: assert property (@(posedge clk) disable iff (rst)
        (|is_inv) |-> is_inv[vic]);
    assert_pick_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (!(|is_inv) && (|is_cl)) |-> is_cl[vic]);
    assert_pick_dirty_R4: assert property (@(posedge clk) disable iff (rst)
        is_dt[vic] |-> (&is_dt));

endmodule

// File: rtl/io_line_cache.sv
module io_line_cache
    import io_cache_pkg::*;
#(
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int ADDR_W    = 16,
    parameter int LINE_BITS = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wt_mode,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LINE_BITS-1:0] req_wdata,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [LINE_BITS-1:0] resp_rdata,
    output logic                 mem_req_valid,
    output logic                 mem_req_write,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [LINE_BITS-1:0] mem_req_wdata,
    input  logic                 mem_req_ready,
    input  logic                 mem_rvalid,
    input  logic [LINE_BITS-1:0] mem_rdata
);
    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int CNT_W = $clog2(SETS*WAYS + 1);

    line_st_e             st_q  [SETS][WAYS];
    logic [TAG_W-1:0]     tag_q [SETS][WAYS];
    logic [LINE_BITS-1:0] dat_q [SETS][WAYS];

    fsm_e                 fsm;
    op_e                  op_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [LINE_BITS-1:0] wdata_q;
    logic                 wt_q, hit_q;
    logic [IDX_W-1:0]     vic_q;

    logic [SET_W-1:0]     set_q;
    logic [TAG_W-1:0]     tag_in;
    logic                 hit;
    logic [IDX_W-1:0]     hit_w, vic_w;
    logic [WAYS*2-1:0]    st_flat;
    logic [WAYS*IDX_W-1:0] age_flat;
    logic                 touch_en;
    logic [IDX_W-1:0]     touch_way;

    assign set_q  = addr_q[SET_W-1:0];
    assign tag_in = addr_q[ADDR_W-1:SET_W];

    always_comb begin
        hit = 1'b0; hit_w = '0;
        for (int w = 0; w < WAYS; w++) begin
            st_flat[w*2 +: 2] = st_q[set_q][w];
            if (st_q[set_q][w] != LN_INV && tag_q[set_q][w] == tag_in) begin
                hit   = 1'b1;
                hit_w = IDX_W'(w);
            end
        end
    end

    assign touch_en  = (fsm == F_LOOK && hit && op_q != OP_DMA_WR) ||
                       (fsm == F_PUT) || (fsm == F_WAIT && mem_rvalid);
    assign touch_way = (fsm == F_LOOK) ? hit_w : vic_q;

    io_cache_age #(.SETS(SETS), .WAYS(WAYS)) u_age (
        .clk(clk), .rst(rst), .rd_set(set_q), .touch_en(touch_en),
        .touch_set(set_q), .touch_way(touch_way), .age_flat(age_flat)
    );

    io_cache_victim #(.WAYS(WAYS)) u_victim (
        .clk(clk), .rst(rst), .st_flat(st_flat), .age_flat(age_flat), .vic(vic_w)
    );

    assign req_ready     = (fsm == F_IDLE);
    assign mem_req_valid = (fsm == F_EVICT) || (fsm == F_FETCH) || (fsm == F_THRU);
    assign mem_req_write = (fsm == F_EVICT) || (fsm == F_THRU);
    assign mem_req_addr  = (fsm == F_EVICT) ? {tag_q[set_q][vic_q], set_q} : addr_q;
    assign mem_req_wdata = (fsm == F_EVICT) ? dat_q[set_q][vic_q] :
                           (fsm == F_THRU)  ? wdata_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm        <= F_IDLE;
            op_q       <= OP_DMA_RD;
            addr_q     <= '0;
            wdata_q    <= '0;
            wt_q       <= 1'b0;
            hit_q      <= 1'b0;
            vic_q      <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_rdata <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_q[s][w] <= LN_INV;
        end else begin
            resp_valid <= 1'b0;
            case (fsm)
                F_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    wt_q    <= wt_mode;
                    fsm     <= F_LOOK;
                end
                F_LOOK: begin
                    hit_q <= hit;
                    if (hit && op_q != OP_DMA_WR) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_rdata <= dat_q[set_q][hit_w];
                        fsm        <= F_IDLE;
                    end else if (hit) begin
                        vic_q <= hit_w;
                        fsm   <= F_PUT;
                    end else if (op_q == OP_CPU_RD) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_rdata <= '0;
                        fsm        <= F_IDLE;
                    end else begin
                        vic_q <= vic_w;
                        if (st_q[set_q][vic_w] == LN_DIRTY) fsm <= F_EVICT;
                        else if (op_q == OP_DMA_RD)        fsm <= F_FETCH;
                        else                               fsm <= F_PUT;
                    end
                end
                F_EVICT: if (mem_req_ready) begin
                    st_q[set_q][vic_q] <= LN_INV;
                    fsm <= (op_q == OP_DMA_RD) ? F_FETCH : F_PUT;
                end
                F_FETCH: if (mem_req_ready) fsm <= F_WAIT;
                F_WAIT: if (mem_rvalid) begin
                    tag_q[set_q][vic_q] <= tag_in;
                    dat_q[set_q][vic_q] <= mem_rdata;
                    st_q[set_q][vic_q]  <= LN_CLEAN;
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b0;
                    resp_rdata <= mem_rdata;
                    fsm        <= F_IDLE;
                end
                F_PUT: begin
                    tag_q[set_q][vic_q] <= tag_in;
                    dat_q[set_q][vic_q] <= wdata_q;
                    st_q[set_q][vic_q]  <= wt_q ? LN_CLEAN : LN_DIRTY;
                    if (wt_q) fsm <= F_THRU;
                    else begin
                        resp_valid <= 1'b1;
                        resp_hit   <= hit_q;
                        resp_rdata <= '0;
                        fsm        <= F_IDLE;
                    end
                end
                F_THRU: if (mem_req_ready) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= hit_q;
                    resp_rdata <= '0;
                    fsm        <= F_IDLE;
                end
                default: fsm <= F_IDLE;
            endcase
        end
    end

    // number of Dirty lines in the whole array
    logic [CNT_W-1:0] dirty_cnt;
    always_comb begin
        dirty_cnt = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (st_q[s][w] == LN_DIRTY) dirty_cnt = dirty_cnt + CNT_W'(1);
    end

    assert_wt_never_dirty_R7: assert property (@(posedge clk) disable iff (rst)
        (dirty_cnt > $past(dirty_cnt)) |-> !$past(wt_q));
    assert_fetch_after_wb_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> (st_q[set_q][vic_q] != LN_DIRTY));
    assert_wr_no_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> (op_q == OP_DMA_RD));
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
         $stable(mem_req_wdata)));
    assert_lookup_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (fsm == F_LOOK && op_q == OP_CPU_RD && !hit) |=> (!mem_req_valid && resp_valid && !resp_hit));

endmodule

// File: tb/io_line_cache_bench.sv
`timescale 1ns/1ps
module io_line_cache_bench;
    localparam int SETS = 4, WAYS = 4, AW = 8, LB = 32;

    logic          clk = 0, rst = 1, wt_mode = 0;
    logic          req_valid = 0, req_ready;
    logic [1:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [LB-1:0] req_wdata = 0;
    logic          resp_valid, resp_hit;
    logic [LB-1:0] resp_rdata;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [LB-1:0] mem_req_wdata;
    logic          mem_req_ready = 0, mem_rvalid = 0;
    logic [LB-1:0] mem_rdata = 0;

    io_line_cache #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(AW), .LINE_BITS(LB)) u_io_line_cache (
        .clk(clk), .rst(rst), .wt_mode(wt_mode), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_rdata(resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LB-1:0] act, input logic [LB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [LB-1:0] init_val(input int a);
        logic [7:0] b = 8'(a);
        return {b, ~b, b ^ 8'h5A, 8'hC3};
    endfunction

    // memory model
    logic [LB-1:0] mem [256];
    logic [LB-1:0] exp_mem [256];
    int wr_cnt = 0, rd_cnt = 0, ev = 0, last_wr_ev = 0, last_rd_ev = 0, rcnt = 0;
    logic [AW-1:0] last_wr_addr = 0, pend_addr = 0;
    logic [LB-1:0] last_wr_data = 0;
    bit pend = 0;

    always @(posedge clk) begin
        if (!rst && mem_req_valid && mem_req_ready) begin
            ev++;
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt++; last_wr_ev = ev;
                last_wr_addr = mem_req_addr; last_wr_data = mem_req_wdata;
            end else begin
                rd_cnt++; last_rd_ev = ev;
                pend = 1; pend_addr = mem_req_addr;
            end
        end
    end

    always @(negedge clk) begin
        mem_rvalid <= pend;
        mem_rdata  <= pend ? mem[pend_addr] : '0;
        pend = 0;
        rcnt++;
        mem_req_ready <= ((rcnt % 3) != 1) && ((rcnt % 7) != 3);
    end

    // reference model: state 0 Invalid, 1 Clean, 2 Dirty; recency by timestamps
    int m_st [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_stamp [SETS][WAYS];
    logic [LB-1:0] m_dat [SETS][WAYS];
    int now = 0;

    task automatic do_op(input int op, input int addr, input logic [LB-1:0] wd,
                         input logic wt, input string req);
        int s = addr % SETS, t = addr / SETS, hw = -1, v = -1;
        bit exp_hit = 0, wb = 0;
        int exp_wr = 0, exp_rd = 0, wr0 = wr_cnt, rd0 = rd_cnt;
        logic [LB-1:0] exp_data = '0, e_wdata = '0;
        int e_waddr = 0;
        for (int w = 0; w < WAYS; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) hw = w;
        now++;
        if (hw >= 0) begin
            exp_hit = 1;
            m_stamp[s][hw] = now;
            if (op != 1) exp_data = m_dat[s][hw];
            else begin
                m_dat[s][hw] = wd;
                m_st[s][hw] = wt ? 1 : 2;
                if (wt) begin exp_wr++; e_waddr = addr; e_wdata = wd; exp_mem[addr] = wd; end
            end
        end else if (op != 2) begin
            for (int w = WAYS - 1; w >= 0; w--) if (m_st[s][w] == 0) v = w;
            for (int k = 1; k <= 2 && v < 0; k++) begin
                int best = -1;
                for (int w = 0; w < WAYS; w++)
                    if (m_st[s][w] == k && (best < 0 || m_stamp[s][w] < m_stamp[s][best])) best = w;
                v = best;
            end
            if (m_st[s][v] == 2) begin
                wb = 1; exp_wr++;
                e_waddr = m_tag[s][v] * SETS + s; e_wdata = m_dat[s][v];
                exp_mem[e_waddr] = e_wdata;
            end
            if (op == 0) begin
                exp_rd++;
                exp_data = exp_mem[addr];
                m_dat[s][v] = exp_data; m_st[s][v] = 1;
            end else begin
                m_dat[s][v] = wd; m_st[s][v] = wt ? 1 : 2;
                if (wt) begin exp_wr++; e_waddr = addr; e_wdata = wd; exp_mem[addr] = wd; end
            end
            m_tag[s][v] = t; m_stamp[s][v] = now;
        end
        // drive the request
        req_op = 2'(op); req_addr = AW'(addr); req_wdata = wd; wt_mode = wt; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!resp_valid) @(negedge clk);
        chk(resp_hit == exp_hit, req, "hit", LB'(resp_hit), LB'(exp_hit));
        chk(resp_rdata == exp_data, req, "rdata", resp_rdata, exp_data);
        chk(wr_cnt - wr0 == exp_wr, req, "mem writes", LB'(wr_cnt - wr0), LB'(exp_wr));
        chk(rd_cnt - rd0 == exp_rd, req, "mem reads", LB'(rd_cnt - rd0), LB'(exp_rd));
        if (exp_wr > 0 && wr_cnt - wr0 == exp_wr) begin
            chk(last_wr_addr == AW'(e_waddr), req, "write addr", LB'(last_wr_addr), LB'(e_waddr));
            chk(last_wr_data == e_wdata, req, "write data", last_wr_data, e_wdata);
        end
        if (wb && op == 0 && exp_wr == wr_cnt - wr0 && exp_rd == rd_cnt - rd0)
            chk(last_wr_ev < last_rd_ev, req, "writeback before fetch",
                LB'(last_wr_ev), LB'(last_rd_ev));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] lf = 16'hACE1;
        for (int a = 0; a < 256; a++) begin mem[a] = init_val(a); exp_mem[a] = init_val(a); end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1, "R1", "req_ready after reset", LB'(req_ready), 1);
        chk(resp_valid == 0, "R1", "resp_valid after reset", LB'(resp_valid), 0);
        chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", LB'(mem_req_valid), 0);
        do_op(2, 0, 0, 0, "R1");
        // R10: lookup misses allocate nothing
        do_op(2, 9, 0, 0, "R10");
        do_op(2, 9, 0, 0, "R10");
        // R6: write-allocate, write-back mode fills set 1 with Dirty lines
        for (int t = 0; t < 4; t++) do_op(1, t * 4 + 1, 32'h1000 + t, 0, "R6");
        // R5: CPU lookup hit on tag 2 refreshes its recency
        do_op(2, 2 * 4 + 1, 0, 0, "R5");
        do_op(2, 0 * 4 + 1, 0, 0, "R10");
        // R4 and R9: all Dirty, oldest (tag 1) written back before the fetch
        do_op(0, 4 * 4 + 1, 0, 0, "R4");
        do_op(0, 4 * 4 + 1, 0, 0, "R8");
        // R3: one Clean way among older Dirty ways is replaced with no write-back
        do_op(1, 5 * 4 + 1, 32'h2005, 0, "R3");
        // R2: Invalid ways used before a Clean one is displaced
        do_op(0, 0 * 4 + 2, 0, 0, "R8");
        do_op(0, 1 * 4 + 2, 0, 0, "R2");
        do_op(0, 2 * 4 + 2, 0, 0, "R2");
        do_op(2, 0 * 4 + 2, 0, 0, "R2");
        // R7: write-through evicts a Dirty victim and writes through; hit on Dirty cleans it
        do_op(1, 6 * 4 + 1, 32'h3006, 1, "R7");
        do_op(1, 2 * 4 + 1, 32'h3002, 1, "R7");
        do_op(1, 7 * 4 + 1, 32'h4007, 0, "R7");
        do_op(1, 8 * 4 + 1, 32'h4008, 0, "R7");
        // R8: read miss then read hit in an untouched set
        do_op(0, 3 * 4 + 3, 0, 0, "R8");
        do_op(0, 3 * 4 + 3, 0, 1, "R8");
        // R11 and R5: mixed sweep with an irregular ready
        for (int i = 0; i < 700; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(int'(lf[1:0]) % 3, int'(lf[9:5]), {16'(i), lf}, lf[12] & lf[3], "R11/R5");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule